// File: doc/BRIEF.md
# NaN-Propagating Floating-Point Min/Max Unit

This block is a purely combinational minimum/maximum stage for IEEE-754 binary formats of 16, 32 or 64 bits, chosen with one width parameter. A one-bit select picks minimum or maximum. The unit reads two raw operand bit patterns and returns one of them unchanged, or the canonical quiet NaN of the format.

It differs from the older minNum/maxNum behaviour in one way. When either input is a NaN, the result is always the canonical NaN, even if the other operand is an ordinary number. The comparisons are quiet. The only exception the unit can raise is invalid, and only when a signaling NaN is present.

Signed zeros are ordered so that -0 is below +0. This makes the result independent of operand order whenever the two operands compare equal. The unit sits inside a floating-point execution pipe, and the registers around it belong to the surrounding pipe.

Top module: `fp_minmax_nan`

## Requirements
- R1: When either operand has an all-ones exponent and a nonzero fraction (a NaN), `result` equals the canonical NaN: 0x7E00 for WIDTH=16, 0x7FC00000 for WIDTH=32, 0x7FF8000000000000 for WIDTH=64.
- R2: With `op_is_max`=1 and no NaN input, `result` is `src_a` if `src_b` < `src_a`, or if they compare equal and `src_b` has bit WIDTH-1 set. Otherwise `result` is `src_b`.
- R3: With `op_is_max`=0 and no NaN input, `result` is `src_a` if `src_a` < `src_b`, or if they compare equal and `src_a` has bit WIDTH-1 set. Otherwise `result` is `src_b`.
- R4: +0 and -0 compare equal, and the sign tie-break applies to them. The minimum of +0 and -0 is -0 (0x80000000 in single precision) in either operand order. The maximum is +0 in either operand order.
- R5: `invalid` is 1 exactly when at least one operand is a signaling NaN, meaning a NaN whose fraction MSB is 0. A quiet NaN alone leaves `invalid` at 0.
- R6: Infinities and subnormals are ordered as ordinary values, and a non-NaN result is bit-identical to the operand it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_is_max | input | 1 | 1 selects maximum, 0 selects minimum |
| src_a | input | WIDTH | First operand bit pattern |
| src_b | input | WIDTH | Second operand bit pattern |
| result | output | WIDTH | Selected operand or canonical NaN |
| invalid | output | 1 | Signaling-NaN exception flag |

## Verification
Both results, `result` and `invalid`, depend only on the current inputs. They are due in the same cycle as the operands, with zero register stages. The driver applies operands just after a rising edge and queues the expected pair. The monitor pops and compares that pair at the following falling edge, so each check lands half a cycle after its stimulus and before the next stimulus arrives.

// File: rtl/fp_minmax_nan.sv
module fp_minmax_nan #(
  parameter int WIDTH = 32
) (
  input  logic             op_is_max,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] result,
  output logic             invalid
);
  localparam int EXP_W  = (WIDTH == 16) ? 5 : (WIDTH == 32) ? 8 : 11;
  localparam int FRAC_W = WIDTH - 1 - EXP_W;
  localparam logic [WIDTH-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  if (WIDTH != 16 && WIDTH != 32 && WIDTH != 64) begin : g_bad_width
    $error("fp_minmax_nan: WIDTH must be 16, 32 or 64");
  end

  logic             sgn_a, sgn_b;
  logic [WIDTH-2:0] mag_a, mag_b;
  logic             nan_a, nan_b, snan_a, snan_b;
  logic             zeros, equal, a_below, b_below, take_a;

  assign sgn_a = src_a[WIDTH-1];
  assign sgn_b = src_b[WIDTH-1];
  assign mag_a = src_a[WIDTH-2:0];
  assign mag_b = src_b[WIDTH-2:0];

  assign nan_a  = (&src_a[WIDTH-2 -: EXP_W]) && (|src_a[FRAC_W-1:0]);
  assign nan_b  = (&src_b[WIDTH-2 -: EXP_W]) && (|src_b[FRAC_W-1:0]);
  assign snan_a = nan_a && !src_a[FRAC_W-1];
  assign snan_b = nan_b && !src_b[FRAC_W-1];

  assign zeros = (mag_a == '0) && (mag_b == '0);
  assign equal = zeros || (src_a == src_b);

  always_comb begin
    a_below = 1'b0;
    b_below = 1'b0;
    if (!zeros) begin
      unique case ({sgn_a, sgn_b})
        2'b10: a_below = 1'b1;
        2'b01: b_below = 1'b1;
        2'b00: begin
          a_below = mag_a < mag_b;
          b_below = mag_b < mag_a;
        end
        default: begin
          a_below = mag_a > mag_b;
          b_below = mag_b > mag_a;
        end
      endcase
    end
  end

  assign take_a = op_is_max ? (b_below || (equal && sgn_b))
                            : (a_below || (equal && sgn_a));

  assign result  = (nan_a || nan_b) ? CANON_NAN : (take_a ? src_a : src_b);
  assign invalid = snan_a || snan_b;
endmodule

// File: rtl/fp_minmax_nan_chk.sv
module fp_minmax_nan_chk #(
  parameter int WIDTH = 32
) (
  input logic             op_is_max,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [WIDTH-1:0] result,
  input logic             invalid
);
  localparam int EXP_W  = (WIDTH == 16) ? 5 : (WIDTH == 32) ? 8 : 11;
  localparam int FRAC_W = WIDTH - 1 - EXP_W;
  localparam logic [WIDTH-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic any_nan, a_zero, b_zero;
  assign any_nan = ((&src_a[WIDTH-2 -: EXP_W]) && (|src_a[FRAC_W-1:0])) ||
                   ((&src_b[WIDTH-2 -: EXP_W]) && (|src_b[FRAC_W-1:0]));
  assign a_zero = src_a[WIDTH-2:0] == '0;
  assign b_zero = src_b[WIDTH-2:0] == '0;

  always_comb begin
    if (any_nan) begin
      a_r1_canonical_nan: assert (result == QNAN);
    end else begin
      a_r6_result_is_operand: assert (result == src_a || result == src_b);
      a_r5_no_flag_without_nan: assert (!invalid);
    end
    if (!any_nan && a_zero && b_zero && (src_a[WIDTH-1] != src_b[WIDTH-1])) begin
      a_r4_zero_sign: assert (result[WIDTH-1] == !op_is_max);
    end
    if (!any_nan && !src_a[WIDTH-1] && src_b[WIDTH-1] && !(a_zero && b_zero)) begin
      a_r2_r3_sign_order: assert (result == (op_is_max ? src_a : src_b));
    end
  end
endmodule

bind fp_minmax_nan fp_minmax_nan_chk #(.WIDTH(WIDTH)) u_chk (
  .op_is_max(op_is_max), .src_a(src_a), .src_b(src_b),
  .result(result), .invalid(invalid)
);

// File: tb/fp_minmax_nan_bench.sv
module fp_minmax_nan_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        h_max, s_max, d_max;
  logic [15:0] h_a, h_b, h_res;
  logic [31:0] s_a, s_b, s_res;
  logic [63:0] d_a, d_b, d_res;
  logic        h_inv, s_inv, d_inv;

  fp_minmax_nan #(.WIDTH(32)) u_fp_minmax_nan (
    .op_is_max(s_max), .src_a(s_a), .src_b(s_b), .result(s_res), .invalid(s_inv));
  fp_minmax_nan #(.WIDTH(16)) u_half (
    .op_is_max(h_max), .src_a(h_a), .src_b(h_b), .result(h_res), .invalid(h_inv));
  fp_minmax_nan #(.WIDTH(64)) u_dbl (
    .op_is_max(d_max), .src_a(d_a), .src_b(d_b), .result(d_res), .invalid(d_inv));

  typedef struct {
    int          fmt;
    logic [63:0] res;
    logic        inv;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic drive(input int fmt, input logic mx, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] er,
                       input logic ei, input string req);
    item_t it;
    @(posedge clk);
    #1;
    case (fmt)
      16: begin h_max = mx; h_a = a[15:0]; h_b = b[15:0]; end
      64: begin d_max = mx; d_a = a; d_b = b; end
      default: begin s_max = mx; s_a = a[31:0]; s_b = b[31:0]; end
    endcase
    it.fmt = fmt; it.res = er; it.inv = ei; it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [63:0] got;
      logic gi;
      it = q.pop_front();
      case (it.fmt)
        16: begin got = {48'd0, h_res}; gi = h_inv; end
        64: begin got = d_res; gi = d_inv; end
        default: begin got = {32'd0, s_res}; gi = s_inv; end
      endcase
      checks++;
      if (got !== it.res || gi !== it.inv) begin
        errors++;
        $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                 it.req, got, gi, it.res, it.inv);
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    h_max = 0; h_a = 0; h_b = 0;
    s_max = 0; s_a = 0; s_b = 0;
    d_max = 0; d_a = 0; d_b = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(32, 1, 0, 0, 0, 0, "R2 idle zeros");
    drive(32, 1, 32'h3F800000, 32'h40000000, 32'h40000000, 0, "R2");
    drive(32, 1, 32'h40000000, 32'h3F800000, 32'h40000000, 0, "R2");
    drive(32, 1, 32'hBF800000, 32'h3F800000, 32'h3F800000, 0, "R2");
    drive(32, 1, 32'hC0600000, 32'hBF800000, 32'hBF800000, 0, "R2");
    drive(32, 1, 32'h40000000, 32'h40000000, 32'h40000000, 0, "R2");
    drive(32, 0, 32'h3F800000, 32'h40000000, 32'h3F800000, 0, "R3");
    drive(32, 0, 32'h40000000, 32'h3F800000, 32'h3F800000, 0, "R3");
    drive(32, 0, 32'hBF800000, 32'h3F800000, 32'hBF800000, 0, "R3");
    drive(32, 0, 32'hC0600000, 32'hBF800000, 32'hC0600000, 0, "R3");
    drive(32, 1, 32'h00000000, 32'h80000000, 32'h00000000, 0, "R4");
    drive(32, 1, 32'h80000000, 32'h00000000, 32'h00000000, 0, "R4");
    drive(32, 0, 32'h00000000, 32'h80000000, 32'h80000000, 0, "R4");
    drive(32, 0, 32'h80000000, 32'h00000000, 32'h80000000, 0, "R4");
    drive(32, 0, 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 0, "R1");
    drive(32, 1, 32'h3F800000, 32'hFFC00000, 32'h7FC00000, 0, "R1");
    drive(32, 1, 32'h7F800001, 32'h3F800000, 32'h7FC00000, 1, "R5");
    drive(32, 0, 32'h3F800000, 32'hFF800005, 32'h7FC00000, 1, "R5");
    drive(32, 0, 32'h7F800001, 32'h7FC00000, 32'h7FC00000, 1, "R5");
    drive(32, 1, 32'h7F800000, 32'hFF800000, 32'h7F800000, 0, "R6");
    drive(32, 0, 32'h7F800000, 32'hFF800000, 32'hFF800000, 0, "R6");
    drive(32, 0, 32'h00000001, 32'h00000000, 32'h00000000, 0, "R6");
    drive(32, 1, 32'h00000001, 32'h00000000, 32'h00000001, 0, "R6");
    drive(32, 1, 32'h807FFFFF, 32'h80000001, 32'h80000001, 0, "R6");
    drive(16, 1, 16'h3C00, 16'h4000, 16'h4000, 0, "R2");
    drive(16, 0, 16'h7E01, 16'h3C00, 16'h7E00, 0, "R1");
    drive(16, 1, 16'h7C01, 16'h3C00, 16'h7E00, 1, "R5");
    drive(16, 0, 16'h0000, 16'h8000, 16'h8000, 0, "R4");
    drive(64, 0, 64'h3FF0000000000000, 64'hBFF0000000000000,
          64'hBFF0000000000000, 0, "R3");
    drive(64, 1, 64'h7FF0000000000001, 64'h0, 64'h7FF8000000000000, 1, "R5");
    drive(64, 1, 64'h7FF8000000000001, 64'h0, 64'h7FF8000000000000, 0, "R1");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule